// File: doc/BRIEF.md
# Self-Tuning Fundamental Extractor

This block takes one set of three-phase samples per strobe, either voltages or currents, and maps them onto two stationary axes with a power-invariant transform. Two integrators then run with cross-coupling between them, one per axis. Each integrator is pulled toward its axis input at a rate set by the gain coefficient. It is also rotated by the other axis at the programmed angular frequency. As a result, only the component at that frequency passes, with unity gain and no phase lag, and no phase-locked loop is needed.

On each axis the block outputs the extracted fundamental. It also outputs the harmonic residue, which is the axis input minus the new fundamental estimate. A downstream compensator uses the residue as its harmonic reference. The gain and frequency arrive as signed Q1.15 products with the sample period, K·Ts and w0·Ts. At a 10 kHz sample rate, a 50 Hz fundamental corresponds to w0·Ts = 1029.

Top module: `stf_extractor`

## Requirements
- R1: The axis values are formed as alpha = ((2a − b − c)·26755) >>> 16 and beta = ((b − c)·23170) >>> 15. The shifts are arithmetic, so they round toward minus infinity, and the constants are sqrt(2/3) and 1/sqrt(2) in Q1.15.
- R2: On a strobe, the alpha state F_a becomes F_a + ((k_ts·(alpha − F_a)) >>> 15) − ((w_ts·F_b) >>> 15). Both terms use the states from before the strobe.
- R3: On a strobe, the beta state F_b becomes F_b + ((k_ts·(beta − F_b)) >>> 15) + ((w_ts·F_a) >>> 15). Both terms use the states from before the strobe.
- R4: On each axis, the residue output equals the axis input minus the updated state, taken from the same strobe.
- R5: out_valid is high exactly in the cycle after a cycle with in_valid high. Outputs appear at that point.
- R6: Without a strobe, the states and all outputs keep their values.
- R7: Synchronous reset clears both states, both residues and out_valid. A strobe during reset is ignored.
- R8: Every state and residue update saturates to the 32-bit signed range and never wraps.
- R9: With k_ts = 655, w_ts = 1029 and a 10 kHz sample rate, the input is a 50 Hz fundamental of amplitude X plus 5th and 7th harmonics. Once settled, the peak of fund_a lies within 10 % of 1.2247·X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| ph_a | input | 18 | Phase a sample, signed |
| ph_b | input | 18 | Phase b sample, signed |
| ph_c | input | 18 | Phase c sample, signed |
| k_ts | input | 16 | Gain times sample period, signed Q1.15 |
| w_ts | input | 16 | Angular frequency times sample period, signed Q1.15 |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| fund_a | output | 32 | Alpha fundamental estimate |
| fund_b | output | 32 | Beta fundamental estimate |
| harm_a | output | 32 | Alpha residue |
| harm_b | output | 32 | Beta residue |

## Verification
The bench runs a behavioural integer model on every sample and compares all four outputs against it. This catches three classes of error:
- A swapped sign on a cross term, or coupling through the already updated state, drifts the estimates away from the model within a few samples.
- A residue taken against the old state is off by one update step.
- A shift that rounds toward zero in place of floor differs on negative values.

Gaps in the strobe show whether the states hold still. A reset in the middle of a run, with a strobe held high, shows whether the reset takes priority. A deliberately unstable gain drives a state toward full scale, where a wrapping adder would flip sign instead of clamping. A settled-amplitude check catches a wrong transform scale or lost unity gain at the tuned frequency.

// File: rtl/stf_pkg.sv
package stf_pkg;
  // sqrt(2/3) and 1/sqrt(2) in Q1.15
  localparam int CLK_ALPHA_Q15 = 26755;
  localparam int CLK_BETA_Q15  = 23170;
  localparam int COEF_FRAC     = 15;
endpackage

// File: rtl/stf_clarke.sv
module stf_clarke #(
  parameter int IN_W = 18,
  parameter int AX_W = IN_W + 2
) (
  input  logic signed [IN_W-1:0] ph_a,
  input  logic signed [IN_W-1:0] ph_b,
  input  logic signed [IN_W-1:0] ph_c,
  output logic signed [AX_W-1:0] ax_alpha,
  output logic signed [AX_W-1:0] ax_beta
);
  import stf_pkg::*;
  localparam int S_W = IN_W + 2;
  localparam int P_W = S_W + 17;

  logic signed [S_W-1:0] sum_a, dif_bc;
  logic signed [P_W-1:0] prod_a, prod_b;

  always_comb begin
    sum_a  = 2 * S_W'(ph_a) - S_W'(ph_b) - S_W'(ph_c);
    dif_bc = S_W'(ph_b) - S_W'(ph_c);
    prod_a = P_W'(sum_a) * P_W'(CLK_ALPHA_Q15);
    prod_b = P_W'(dif_bc) * P_W'(CLK_BETA_Q15);
    ax_alpha = AX_W'(prod_a >>> (COEF_FRAC + 1));
    ax_beta  = AX_W'(prod_b >>> COEF_FRAC);
  end
endmodule

// File: rtl/stf_axis_step.sv
module stf_axis_step #(
  parameter int AX_W    = 20,
  parameter int ACC_W   = 32,
  parameter int COEF_W  = 16,
  parameter bit NEG_XC  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [AX_W-1:0]   ax_in,
  input  logic signed [ACC_W-1:0]  own_st,
  input  logic signed [ACC_W-1:0]  peer_st,
  input  logic signed [COEF_W-1:0] k_ts,
  input  logic signed [COEF_W-1:0] w_ts,
  output logic signed [ACC_W-1:0]  nxt_st
);
  import stf_pkg::*;
  localparam int E_W = ACC_W + 1;
  localparam int P_W = E_W + COEF_W;
  localparam int S_W = P_W + 2;
  localparam logic signed [S_W-1:0] MAXV = S_W'({1'b0, {(ACC_W-1){1'b1}}});
  localparam logic signed [S_W-1:0] MINV = -MAXV - 1;

  logic signed [E_W-1:0] err;
  logic signed [P_W-1:0] pk, pw;
  logic signed [S_W-1:0] term, total;

  always_comb begin
    err   = E_W'(ax_in) - E_W'(own_st);
    pk    = P_W'(k_ts) * P_W'(err);
    pw    = P_W'(w_ts) * P_W'(peer_st);
    if (NEG_XC) term = S_W'(pk >>> COEF_FRAC) - S_W'(pw >>> COEF_FRAC);
    else        term = S_W'(pk >>> COEF_FRAC) + S_W'(pw >>> COEF_FRAC);
    total = S_W'(own_st) + term;
    if (total > MAXV)      nxt_st = MAXV[ACC_W-1:0];
    else if (total < MINV) nxt_st = MINV[ACC_W-1:0];
    else                   nxt_st = total[ACC_W-1:0];
  end

  // R8
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (own_st >= 0 && term >= 0) |-> (nxt_st >= 0));
  // R8
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (own_st < 0 && term < 0) |-> (nxt_st < 0));
endmodule

// File: rtl/stf_extractor.sv
module stf_extractor #(
  parameter int IN_W   = 18,
  parameter int ACC_W  = 32,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   ph_a,
  input  logic signed [IN_W-1:0]   ph_b,
  input  logic signed [IN_W-1:0]   ph_c,
  input  logic signed [COEF_W-1:0] k_ts,
  input  logic signed [COEF_W-1:0] w_ts,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  fund_a,
  output logic signed [ACC_W-1:0]  fund_b,
  output logic signed [ACC_W-1:0]  harm_a,
  output logic signed [ACC_W-1:0]  harm_b
);
  localparam int AX_W = IN_W + 2;
  localparam int D_W  = ACC_W + 1;
  localparam logic signed [D_W-1:0] MAXD = D_W'({1'b0, {(ACC_W-1){1'b1}}});
  localparam logic signed [D_W-1:0] MIND = -MAXD - 1;

  logic signed [AX_W-1:0]  ax [2];
  logic signed [ACC_W-1:0] st [2];
  logic signed [ACC_W-1:0] nx [2];
  logic signed [ACC_W-1:0] rs [2];

  stf_clarke #(.IN_W(IN_W), .AX_W(AX_W)) u_clarke (
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .ax_alpha(ax[0]), .ax_beta(ax[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic signed [D_W-1:0] dif;
    stf_axis_step #(.AX_W(AX_W), .ACC_W(ACC_W), .COEF_W(COEF_W),
                    .NEG_XC(g == 0)) u_step (
      .clk(clk), .rst(rst), .ax_in(ax[g]), .own_st(st[g]),
      .peer_st(st[1-g]), .k_ts(k_ts), .w_ts(w_ts), .nxt_st(nx[g])
    );
    always_comb begin
      dif = D_W'(ax[g]) - D_W'(nx[g]);
      if (dif > MAXD)      rs[g] = MAXD[ACC_W-1:0];
      else if (dif < MIND) rs[g] = MIND[ACC_W-1:0];
      else                 rs[g] = dif[ACC_W-1:0];
    end
  end

  logic signed [ACC_W-1:0] res_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        st[i]    <= '0;
        res_q[i] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < 2; i++) begin
          st[i]    <= nx[i];
          res_q[i] <= rs[i];
        end
      end
    end
  end

  assign fund_a = st[0];
  assign fund_b = st[1];
  assign harm_a = res_q[0];
  assign harm_b = res_q[1];

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(fund_a) && $stable(fund_b) && $stable(harm_a)));
  // R7
  reset_chk: assert property (@(posedge clk)
    rst |=> (fund_a == 0 && fund_b == 0 && !out_valid));
endmodule

// File: tb/tb_stf_extractor.sv
module tb_stf_extractor;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic signed [17:0] ph_a = 0, ph_b = 0, ph_c = 0;
  logic signed [15:0] k_ts = 0, w_ts = 0;
  logic out_valid;
  logic signed [31:0] fund_a, fund_b, harm_a, harm_b;

  int checks = 0, errors = 0;
  longint ma = 0, mb = 0, ha = 0, hb = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stf_extractor dut (.*);

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model update for one strobe, then compare after the capturing edge
  task automatic step(int a, int b, int c);
    longint al, be, na, nb, kk, ww;
    kk = k_ts; ww = w_ts;
    al = ((2*longint'(a) - b - c) * 26755) >>> 16;           // R1
    be = ((longint'(b) - c) * 23170) >>> 15;
    na = sat32(ma + ((kk*(al-ma)) >>> 15) - ((ww*mb) >>> 15)); // R2
    nb = sat32(mb + ((kk*(be-mb)) >>> 15) + ((ww*ma) >>> 15)); // R3
    ha = sat32(al - na); hb = sat32(be - nb);                  // R4
    ma = na; mb = nb;
    ph_a = 18'(a); ph_b = 18'(b); ph_c = 18'(c); in_valid = 1;
    @(negedge clk);
    chk("R5", out_valid, 1);
    chk("R2", fund_a, ma);
    chk("R3", fund_b, mb);
    chk("R4", harm_a, ha);
    chk("R4", harm_b, hb);
  endtask

  task automatic gap();
    in_valid = 0; ph_a = 18'sd77; ph_b = -18'sd500; ph_c = 18'sd9000;
    @(negedge clk);
    chk("R5", out_valid, 0);
    chk("R6", fund_a, ma);
    chk("R6", fund_b, mb);
    chk("R6", harm_a, ha);
    chk("R6", harm_b, hb);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    real th, pi, x;
    longint peak;
    int a, b, c;
    pi = 3.14159265358979; x = 60000.0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    chk("R7", out_valid, 0);
    chk("R7", fund_a, 0);
    chk("R7", harm_b, 0);

    // R1: static cases
    k_ts = 16'sd32767; w_ts = 0;
    step(1000, -3, 7);
    step(-1, -1, 2);
    gap();
    step(-131072, 131071, 131071);
    gap(); gap();

    // reset mid-run with strobe high: ignored (R7)
    rst = 1; in_valid = 1; ph_a = 18'sd5000;
    @(negedge clk); @(negedge clk);
    chk("R7", out_valid, 0);
    chk("R7", fund_a, 0);
    chk("R7", fund_b, 0);
    chk("R7", harm_a, 0);
    rst = 0; in_valid = 0; ma = 0; mb = 0; ha = 0; hb = 0;
    @(negedge clk);

    // R9: 50 Hz at 10 kHz plus 5th and 7th
    k_ts = 16'sd655; w_ts = 16'sd1029;
    peak = 0;
    for (int n = 0; n < 1400; n++) begin
      th = 2.0*pi*50.0*n/10000.0;
      a = int'(x*($sin(th) + 0.2*$sin(5*th) + 0.14*$sin(7*th)));
      b = int'(x*($sin(th-2*pi/3) + 0.2*$sin(5*(th-2*pi/3)) + 0.14*$sin(7*(th-2*pi/3))));
      c = int'(x*($sin(th+2*pi/3) + 0.2*$sin(5*(th+2*pi/3)) + 0.14*$sin(7*(th+2*pi/3))));
      step(a, b, c);
      if (n >= 1200 && fund_a > peak) peak = fund_a;
      if (n % 300 == 17) gap();
    end
    checks++;
    if (peak < longint'(0.9*1.2247*x) || peak > longint'(1.1*1.2247*x)) begin
      errors++;
      $display("FAIL R9 actual %0d expected %0d", peak, longint'(1.2247*x));
    end

    // R8: unstable gain forces saturation, no wrap
    rst = 1; @(negedge clk); rst = 0; in_valid = 0;
    ma = 0; mb = 0; ha = 0; hb = 0;
    @(negedge clk);
    k_ts = -16'sd32768; w_ts = 0;
    for (int n = 0; n < 20; n++) step(100000, 0, 0);
    chk("R8", fund_a, -64'sd2147483648);
    step(100000, 0, 0);
    chk("R8", fund_a, -64'sd2147483648);
    chk("R8", harm_a, 64'sd2147483647);
    gap();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule